// File: doc/BRIEF.md
# PWM Drive Conditioning for a Three-Phase Bridge

This block sits between a three-phase PWM timing generator and the gate drivers of an inverter. It receives a high-side and a low-side raw pulse train for each of the three phases, A, B and C. Per phase, it can swap the two signals of that pair, which suits block-commutated motor control. It can then mask any of the six physical drive pins on its own. Each conditioned value is registered once before it leaves the block.

A trip input from an overcurrent comparator is brought into the clock domain through two flops and held in a sticky latch. While the latch is set, or is being set, all six drive pins are held low. The latch releases only on reset or on an explicit clear. A one-cycle interrupt pulse marks each new trip. Configuration arrives as a 9-bit control word from a register held elsewhere.

Top module: `pwm_drive_cond`

## Requirements
- R1: While `rst_n` is low at a rising edge, that edge drives all six outputs and `trip_irq` to 0 and clears the trip state.
- R2: With `seg_ctl` = 0, after each rising edge `drv_hi[p]` equals the `raw_hi[p]` sampled at that edge, and `drv_lo[p]` equals the sampled `raw_lo[p]`. The phase index p is 0 for A, 1 for B and 2 for C.
- R3: `seg_ctl[p]` = 1 swaps phase p: `raw_hi[p]` is routed to the low-side pin and `raw_lo[p]` to the high-side pin. Bit 0 is A, bit 1 is B, bit 2 is C.
- R4: A 1 in a disable bit forces its pin to 0. Bit 3 disables AH, bit 4 AL, bit 5 BH, bit 6 BL, bit 7 CH and bit 8 CL. A 0 in a disable bit leaves the pin driven.
- R5: Masking is applied after the swap, so a disable bit always refers to the physical pin, whatever the swap setting.
- R6: When `trip_in` is high at rising edges k, k+1 and k+2, all six outputs are 0 from edge k+2 onward. Edges before k+2 are not affected.
- R7: Once set, the trip state holds all outputs at 0 after `trip_in` returns low, for as long as `trip_clr` stays low.
- R8: `trip_clr` high at an edge releases the outputs at that same edge, provided the synchronized trip is low. While the synchronized trip is still high, the clear has no effect.
- R9: `trip_irq` is high for exactly one cycle, after the edge at which the trip state goes from clear to set. No further pulse occurs while the trip state stays set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| raw_hi | input | 3 | Raw high-side PWM, index 0=A, 1=B, 2=C |
| raw_lo | input | 3 | Raw low-side PWM, same indexing |
| seg_ctl | input | 9 | [2:0] swap per phase, [8:3] pin disables |
| trip_in | input | 1 | Asynchronous shutdown request, active high |
| trip_clr | input | 1 | Synchronous clear of the trip latch |
| drv_hi | output | 3 | Conditioned high-side drive, active high |
| drv_lo | output | 3 | Conditioned low-side drive, active high |
| trip_irq | output | 1 | One-cycle pulse on a new trip |

## Verification
The assertions assume that `rst_n` is held low for at least one edge before any check applies, so that `$past` of `seg_ctl` refers to a driven value. They also assume that `trip_clr` is an ordinary synchronous level. The stimulus changes every input only at falling edges, and it keeps `seg_ctl` defined from the first reset cycle on. It holds `trip_in` steady for several cycles at a time, so that the expected latency through the two-flop synchronizer is deterministic. Clears are issued both while the synchronized trip is low and while it is high.

// File: rtl/pwm_drive_pkg.sv
// Package: shared sizes and the bit layout of the segment control word.
// Assumes three phases; the disable bits are laid out per pin, high side first.
package pwm_drive_pkg;
    localparam int NPH   = 3;
    localparam int SEG_W = 2 * NPH + NPH;

    // Bit position of the swap control for phase p
    function automatic int xov_bit(input int p);
        return p;
    endfunction

    // Bit position of the high-side disable for phase p
    function automatic int dis_hi_bit(input int p);
        return NPH + 2 * p;
    endfunction

    // Bit position of the low-side disable for phase p
    function automatic int dis_lo_bit(input int p);
        return NPH + 2 * p + 1;
    endfunction
endpackage

// File: rtl/pwm_phase_lane.sv
// Module: combinational swap-then-mask path for one phase pair.
// Assumes the caller registers the results; PH selects the control bits used.
module pwm_phase_lane
    import pwm_drive_pkg::*;
#(
    parameter int PH = 0
) (
    input  logic             raw_hi,
    input  logic             raw_lo,
    input  logic [SEG_W-1:0] seg_ctl,
    output logic             pin_hi,
    output logic             pin_lo
);
    localparam int XB = xov_bit(PH);
    localparam int HB = dis_hi_bit(PH);
    localparam int LB = dis_lo_bit(PH);

    logic sw_hi;
    logic sw_lo;

    // Route the pair straight through or crossed over
    always_comb begin
        if (seg_ctl[XB]) begin
            sw_hi = raw_lo;
            sw_lo = raw_hi;
        end else begin
            sw_hi = raw_hi;
            sw_lo = raw_lo;
        end
    end

    // Apply the per-pin disables after the swap
    always_comb begin
        pin_hi = sw_hi & ~seg_ctl[HB];
        pin_lo = sw_lo & ~seg_ctl[LB];
    end
endmodule

// File: rtl/pwm_trip_latch.sv
// Module: two-flop synchronizer, sticky trip latch and the interrupt pulse.
// Assumes trip_in may be asynchronous and trip_clr is synchronous to clk.
module pwm_trip_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic trip_in,
    input  logic trip_clr,
    output logic latch_nx,
    output logic latched,
    output logic irq
);
    logic sync1;
    logic sync2;

    // Bring the trip request into the clock domain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1 <= 1'b0;
            sync2 <= 1'b0;
        end else begin
            sync1 <= trip_in;
            sync2 <= sync1;
        end
    end

    // The next latch state: a synchronized trip wins over a clear
    always_comb latch_nx = sync2 | (latched & ~trip_clr);

    // Hold the latch and pulse the interrupt when it is newly set
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latched <= 1'b0;
            irq     <= 1'b0;
        end else begin
            latched <= latch_nx;
            irq     <= latch_nx & ~latched;
        end
    end

    // R9
    irq_on_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (latched && !$past(latched)));
    // R9
    irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);
    // R7
    latch_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (latched && !trip_clr) |=> latched);
endmodule

// File: rtl/pwm_drive_cond.sv
// Module: top level of the PWM drive conditioner. One lane per phase feeds
// a bank of output registers, and the trip latch forces every pin low.
// Assumes rst_n is synchronous and held low for at least one edge.
module pwm_drive_cond
    import pwm_drive_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPH-1:0]   raw_hi,
    input  logic [NPH-1:0]   raw_lo,
    input  logic [SEG_W-1:0] seg_ctl,
    input  logic             trip_in,
    input  logic             trip_clr,
    output logic [NPH-1:0]   drv_hi,
    output logic [NPH-1:0]   drv_lo,
    output logic             trip_irq
);
    logic [NPH-1:0] pin_hi;
    logic [NPH-1:0] pin_lo;
    logic           kill;
    logic           tripped;

    // One swap-and-mask lane per phase
    for (genvar p = 0; p < NPH; p++) begin : g_lane
        pwm_phase_lane #(.PH(p)) u_lane (
            .raw_hi (raw_hi[p]),
            .raw_lo (raw_lo[p]),
            .seg_ctl(seg_ctl),
            .pin_hi (pin_hi[p]),
            .pin_lo (pin_lo[p])
        );
    end

    pwm_trip_latch u_trip (
        .clk     (clk),
        .rst_n   (rst_n),
        .trip_in (trip_in),
        .trip_clr(trip_clr),
        .latch_nx(kill),
        .latched (tripped),
        .irq     (trip_irq)
    );

    // Register the drive pins, forced low on the edge the trip sets
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drv_hi <= '0;
            drv_lo <= '0;
        end else if (kill) begin
            drv_hi <= '0;
            drv_lo <= '0;
        end else begin
            drv_hi <= pin_hi;
            drv_lo <= pin_lo;
        end
    end

    // R6
    trip_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tripped |-> (drv_hi == '0 && drv_lo == '0));
    // R4
    ah_disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(seg_ctl[dis_hi_bit(0)]) |-> !drv_hi[0]);
    // R4
    cl_disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(seg_ctl[dis_lo_bit(NPH-1)]) |-> !drv_lo[NPH-1]);
endmodule

// File: tb/pwm_drive_cond_tb.sv
module pwm_drive_cond_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] raw_hi = '0;
    logic [2:0] raw_lo = '0;
    logic [8:0] seg_ctl = '0;
    logic       trip_in = 1'b0;
    logic       trip_clr = 1'b0;
    logic [2:0] drv_hi;
    logic [2:0] drv_lo;
    logic       trip_irq;

    typedef struct {
        int         due;
        logic [2:0] hi;
        logic [2:0] lo;
        logic       irq;
        string      rq;
    } exp_t;

    exp_t q[$];
    int   cyc = 0;
    int   checks = 0;
    int   failures = 0;
    bit   done = 0;
    logic td1 = 0, td2 = 0, elat = 0;

    always #10 clk = ~clk;

    pwm_drive_cond u_dut (
        .clk(clk), .rst_n(rst_n), .raw_hi(raw_hi), .raw_lo(raw_lo),
        .seg_ctl(seg_ctl), .trip_in(trip_in), .trip_clr(trip_clr),
        .drv_hi(drv_hi), .drv_lo(drv_lo), .trip_irq(trip_irq)
    );

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: compare outputs with the scoreboard at each falling edge
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].due == cyc) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (drv_hi !== e.hi || drv_lo !== e.lo || trip_irq !== e.irq) begin
                failures++;
                $display("FAIL %s: got hi=%b lo=%b irq=%b expected hi=%b lo=%b irq=%b",
                         e.rq, drv_hi, drv_lo, trip_irq, e.hi, e.lo, e.irq);
            end
        end
    end

    // Requirement model of swap (R3) then mask (R4, R5)
    function automatic void model(input logic [2:0] h, input logic [2:0] l,
                                  input logic [8:0] s,
                                  output logic [2:0] eh, output logic [2:0] el);
        for (int p = 0; p < 3; p++) begin
            logic a, b;
            a = s[p] ? l[p] : h[p];
            b = s[p] ? h[p] : l[p];
            eh[p] = a & ~s[3 + 2*p];
            el[p] = b & ~s[4 + 2*p];
        end
    endfunction

    // Driver: apply one cycle of stimulus and push the expected result
    task automatic step(input logic r, input logic [2:0] h, input logic [2:0] l,
                        input logic [8:0] s, input logic tr, input logic cl,
                        input string rq);
        exp_t e;
        logic [2:0] eh, el;
        logic en;
        @(negedge clk);
        rst_n = r; raw_hi = h; raw_lo = l; seg_ctl = s; trip_in = tr; trip_clr = cl;
        model(h, l, s, eh, el);
        if (!r) begin
            td1 = 0; td2 = 0; elat = 0;
            e = '{cyc + 1, 3'b000, 3'b000, 1'b0, rq};
        end else begin
            en = td2 | (elat & ~cl);
            e = '{cyc + 1, en ? 3'b000 : eh, en ? 3'b000 : el, en & ~elat, rq};
            elat = en;
            td2 = td1;
            td1 = tr;
        end
        q.push_back(e);
    endtask

    initial begin
        #4ms;
        if (!done) begin
            failures++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R1 reset state, with inputs active
        step(0, 3'b111, 3'b111, 9'h000, 1'b1, 1'b0, "R1");
        step(0, 3'b101, 3'b010, 9'h007, 1'b0, 1'b0, "R1");
        step(0, 3'b000, 3'b000, 9'h000, 1'b0, 1'b0, "R1");
        // R2 straight through
        step(1, 3'b101, 3'b010, 9'h000, 1'b0, 1'b0, "R2");
        step(1, 3'b011, 3'b100, 9'h000, 1'b0, 1'b0, "R2");
        step(1, 3'b110, 3'b001, 9'h000, 1'b0, 1'b0, "R2");
        // R3 crossover per phase
        step(1, 3'b111, 3'b000, 9'h005, 1'b0, 1'b0, "R3");
        step(1, 3'b010, 3'b101, 9'h002, 1'b0, 1'b0, "R3");
        step(1, 3'b100, 3'b011, 9'h007, 1'b0, 1'b0, "R3");
        // R4 each disable bit alone
        for (int b = 3; b < 9; b++)
            step(1, 3'b111, 3'b111, 9'(1 << b), 1'b0, 1'b0, "R4");
        step(1, 3'b111, 3'b111, 9'h1F8, 1'b0, 1'b0, "R4");
        // R5 mask acts on the physical pin after the swap
        step(1, 3'b001, 3'b000, 9'h009, 1'b0, 1'b0, "R5");
        step(1, 3'b000, 3'b001, 9'h009, 1'b0, 1'b0, "R5");
        step(1, 3'b000, 3'b100, 9'h104, 1'b0, 1'b0, "R5");
        step(1, 3'b100, 3'b000, 9'h104, 1'b0, 1'b0, "R5");
        // R6 trip latency, R9 interrupt
        step(1, 3'b111, 3'b000, 9'h000, 1'b1, 1'b0, "R6");
        step(1, 3'b111, 3'b000, 9'h000, 1'b1, 1'b0, "R6");
        step(1, 3'b111, 3'b000, 9'h000, 1'b1, 1'b0, "R9");
        step(1, 3'b111, 3'b000, 9'h000, 1'b1, 1'b0, "R9");
        // R7 latched after trip drops
        for (int i = 0; i < 4; i++)
            step(1, 3'b101, 3'b010, 9'h000, 1'b0, 1'b0, "R7");
        // R8 clear with synchronized trip low
        step(1, 3'b101, 3'b010, 9'h000, 1'b0, 1'b1, "R8");
        step(1, 3'b011, 3'b100, 9'h000, 1'b0, 1'b0, "R8");
        // R9 new trip pulses again, no repeat while set
        for (int i = 0; i < 6; i++)
            step(1, 3'b111, 3'b111, 9'h000, 1'b1, 1'b0, "R9");
        // R8 clear ignored while synchronized trip is high
        step(1, 3'b111, 3'b111, 9'h000, 1'b1, 1'b1, "R8");
        step(1, 3'b111, 3'b111, 9'h000, 1'b0, 1'b1, "R8");
        step(1, 3'b111, 3'b111, 9'h000, 1'b0, 1'b1, "R8");
        step(1, 3'b111, 3'b111, 9'h000, 1'b0, 1'b1, "R8");
        step(1, 3'b110, 3'b011, 9'h000, 1'b0, 1'b0, "R8");
        step(1, 3'b000, 3'b000, 9'h000, 1'b0, 1'b0, "R2");
        repeat (3) @(negedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule